// File: doc/BRIEF.md
# Security-Banked Exception Handler Status Register

This block is a 32-bit control and status word that holds the active, pending and enable flags for the system exceptions of a processor that has two security states. One bus address serves both states. The security attribute of each access picks which state a read returns and which state a write changes. Most fault and handler flags exist once per security state, and an access sees only the copy of its own state. The secure-fault flags exist once and are hidden from Non-secure accesses. The bus-fault flags and the NMI active flag exist once and are shared, but a Non-secure access reaches them only when a configuration input grants bus-fault, hard-fault and NMI handling to the Non-secure state. The debug-monitor active flag is shared with no restriction.

The NMI active flag and the Non-secure hard-fault active flag can be cleared from software, but never set from software. A clear takes effect only when the CPU runs in Secure state, writes through the Non-secure view with the grant bit set, and writes a zero at the flag's position. These two flags and the Secure hard-fault active flag are set by exception-entry event inputs. Each write to the register is followed one cycle later by a single-cycle update strobe, so that the pending-exception logic downstream evaluates the flags again. A read returns the assembled word in the same cycle as the request.

Top module: `exc_hstat_reg`

## Requirements
- R1: After reset every flag is zero. The reserved positions 6, 9 and 22 to 31 always read as zero, and writing them has no effect.
- R2: The banked flags have a Secure copy and a Non-secure copy. They sit at these positions: memory-fault active 0, usage-fault active 3, supervisor-call active 7, pendable-service active 10, system-tick active 11, usage-fault pending 12, memory-fault pending 13, supervisor-call pending 15, memory-fault enable 16, usage-fault enable 18. An access with `req_secure`=1 reads and writes only the Secure copy, and an access with `req_secure`=0 reads and writes only the Non-secure copy.
- R3: The secure-fault flags exist in a single copy: active at bit 4, enable at bit 19, pending at bit 20. Secure accesses read and write them. Non-secure reads return zero at these positions, and Non-secure writes leave them unchanged.
- R4: The bus-fault flags exist in a single shared copy: active at bit 1, pending at bit 14, enable at bit 17. They can be read and written when `req_secure`=1 or `ns_grant`=1. Otherwise they read as zero and writes leave them unchanged.
- R5: NMI active sits at bit 5. It reads as set only when `req_secure`=1 or `ns_grant`=1. A write clears it only when all of the following hold: `req_secure`=0, `cpu_secure`=1, `ns_grant`=1, and write data bit 5 is 0. No write ever sets it.
- R6: Hard-fault active sits at bit 2 and is banked. No write changes the Secure copy. The Non-secure copy is cleared only by a write with `req_secure`=0, `cpu_secure`=1, `ns_grant`=1 and data bit 2 equal to 0, and no write sets it.
- R7: Hard-fault pending sits at bit 21 and is banked. A Non-secure write loads the Non-secure copy from data bit 21. Secure writes never change the Secure copy, which stays zero.
- R8: Debug-monitor active sits at bit 8. It is a single flag that every write loads and every read returns, whatever the security attribute.
- R9: `upd_strobe` is high for exactly one cycle, in the cycle after each accepted write. It is low after any cycle that had no write.
- R10: `rd_data` is combinational. It carries the assembled word in the same cycle as a read request (`req_valid`=1, `req_write`=0) and is zero when no read is requested.
- R11: `evt_nmi_enter`, `evt_hf_enter_s` and `evt_hf_enter_ns` set NMI active, Secure hard-fault active and Non-secure hard-fault active at the next edge. When a set and a permitted clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the access (1 = Secure) |
| req_wdata | input | 32 | Write data |
| cpu_secure | input | 1 | CPU currently executing in Secure state |
| ns_grant | input | 1 | Bus-fault, hard-fault and NMI handling granted to Non-secure |
| evt_nmi_enter | input | 1 | NMI handler entry: sets NMI active |
| evt_hf_enter_s | input | 1 | Secure hard-fault entry: sets the Secure hard-fault active flag |
| evt_hf_enter_ns | input | 1 | Non-secure hard-fault entry: sets the Non-secure hard-fault active flag |
| rd_data | output | 32 | Read data for the current request |
| upd_strobe | output | 1 | One-cycle pulse after each write |

## Verification
The situations hardest to reach from the ports are the clear-only flags. No write can set NMI active or Non-secure hard-fault active, so a clear can only be seen after an entry event has set the flag first. A clear also needs a three-input combination that ordinary traffic rarely produces. The bench therefore sweeps every combination of access attribute, CPU state and grant bit against several data patterns. Before every other write it fires the entry events, so each clear rule is tried with the flags both set and clear. A directed cycle then puts an entry event and a permitted clear on the same edge to show that the set wins.

// File: rtl/hstat_pkg.sv
package hstat_pkg;

    localparam int REG_W = 32;

    // bit positions
    localparam int B_MEM_ACT  = 0;
    localparam int B_BUS_ACT  = 1;
    localparam int B_HF_ACT   = 2;
    localparam int B_USG_ACT  = 3;
    localparam int B_SF_ACT   = 4;
    localparam int B_NMI_ACT  = 5;
    localparam int B_SVC_ACT  = 7;
    localparam int B_DBG_ACT  = 8;
    localparam int B_PSV_ACT  = 10;
    localparam int B_TICK_ACT = 11;
    localparam int B_USG_PEND = 12;
    localparam int B_MEM_PEND = 13;
    localparam int B_BUS_PEND = 14;
    localparam int B_SVC_PEND = 15;
    localparam int B_MEM_EN   = 16;
    localparam int B_BUS_EN   = 17;
    localparam int B_USG_EN   = 18;
    localparam int B_SF_EN    = 19;
    localparam int B_SF_PEND  = 20;
    localparam int B_HF_PEND  = 21;

    localparam logic [REG_W-1:0] USED_MASK =
        (REG_W'(1) << B_MEM_ACT)  | (REG_W'(1) << B_BUS_ACT)  | (REG_W'(1) << B_HF_ACT)  |
        (REG_W'(1) << B_USG_ACT)  | (REG_W'(1) << B_SF_ACT)   | (REG_W'(1) << B_NMI_ACT) |
        (REG_W'(1) << B_SVC_ACT)  | (REG_W'(1) << B_DBG_ACT)  | (REG_W'(1) << B_PSV_ACT) |
        (REG_W'(1) << B_TICK_ACT) | (REG_W'(1) << B_USG_PEND) | (REG_W'(1) << B_MEM_PEND) |
        (REG_W'(1) << B_BUS_PEND) | (REG_W'(1) << B_SVC_PEND) | (REG_W'(1) << B_MEM_EN) |
        (REG_W'(1) << B_BUS_EN)   | (REG_W'(1) << B_USG_EN)   | (REG_W'(1) << B_SF_EN) |
        (REG_W'(1) << B_SF_PEND)  | (REG_W'(1) << B_HF_PEND);
    localparam logic [REG_W-1:0] RSV_MASK = ~USED_MASK;

    // One security state's copy of the banked flags
    typedef struct packed {
        logic mem_act;
        logic hf_act;
        logic usg_act;
        logic svc_act;
        logic psv_act;
        logic tick_act;
        logic usg_pend;
        logic mem_pend;
        logic svc_pend;
        logic mem_en;
        logic usg_en;
        logic hf_pend;
    } bank_t;

    // Single-copy flags
    typedef struct packed {
        logic bus_act;
        logic bus_pend;
        logic bus_en;
        logic sf_act;
        logic sf_en;
        logic sf_pend;
        logic nmi_act;
        logic dbg_act;
    } shared_t;

    function automatic bank_t word_to_bank(logic [REG_W-1:0] d);
        bank_t r;
        r.mem_act  = d[B_MEM_ACT];
        r.hf_act   = d[B_HF_ACT];
        r.usg_act  = d[B_USG_ACT];
        r.svc_act  = d[B_SVC_ACT];
        r.psv_act  = d[B_PSV_ACT];
        r.tick_act = d[B_TICK_ACT];
        r.usg_pend = d[B_USG_PEND];
        r.mem_pend = d[B_MEM_PEND];
        r.svc_pend = d[B_SVC_PEND];
        r.mem_en   = d[B_MEM_EN];
        r.usg_en   = d[B_USG_EN];
        r.hf_pend  = d[B_HF_PEND];
        return r;
    endfunction

    function automatic shared_t word_to_shared(logic [REG_W-1:0] d);
        shared_t r;
        r.bus_act  = d[B_BUS_ACT];
        r.bus_pend = d[B_BUS_PEND];
        r.bus_en   = d[B_BUS_EN];
        r.sf_act   = d[B_SF_ACT];
        r.sf_en    = d[B_SF_EN];
        r.sf_pend  = d[B_SF_PEND];
        r.nmi_act  = d[B_NMI_ACT];
        r.dbg_act  = d[B_DBG_ACT];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] bank_to_word(bank_t b);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_MEM_ACT]  = b.mem_act;
        w[B_HF_ACT]   = b.hf_act;
        w[B_USG_ACT]  = b.usg_act;
        w[B_SVC_ACT]  = b.svc_act;
        w[B_PSV_ACT]  = b.psv_act;
        w[B_TICK_ACT] = b.tick_act;
        w[B_USG_PEND] = b.usg_pend;
        w[B_MEM_PEND] = b.mem_pend;
        w[B_SVC_PEND] = b.svc_pend;
        w[B_MEM_EN]   = b.mem_en;
        w[B_USG_EN]   = b.usg_en;
        w[B_HF_PEND]  = b.hf_pend;
        return w;
    endfunction

    // Loads the freely writable banked fields; hard-fault fields are kept
    function automatic bank_t bank_load(bank_t cur, bank_t wf);
        bank_t r;
        r = wf;
        r.hf_act  = cur.hf_act;
        r.hf_pend = cur.hf_pend;
        return r;
    endfunction

endpackage

// File: rtl/hstat_bank.sv
module hstat_bank
    import hstat_pkg::*;
#(
    parameter bit SECURE_BANK = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  hf_clr_ok,
    input  logic  hf_set,
    input  bank_t wf,
    output bank_t q
);

    bank_t q_r;
    bank_t nxt;
    logic  hf_act_nxt;
    logic  hf_pend_nxt;

    generate
        if (SECURE_BANK) begin : g_sec
            // Secure copy: software cannot touch hard-fault state
            assign hf_act_nxt  = hf_set | (q_r.hf_act & ~(hf_clr_ok & ~wf.hf_act));
            assign hf_pend_nxt = q_r.hf_pend;
        end else begin : g_ns
            assign hf_act_nxt  = hf_set | (q_r.hf_act & ~(hf_clr_ok & ~wf.hf_act));
            assign hf_pend_nxt = wr_en ? wf.hf_pend : q_r.hf_pend;
        end
    endgenerate

    always_comb begin
        nxt         = wr_en ? bank_load(q_r, wf) : q_r;
        nxt.hf_act  = hf_act_nxt;
        nxt.hf_pend = hf_pend_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            q_r <= nxt;
        end
    end

    assign q = q_r;

    generate
        if (SECURE_BANK) begin : g_sec_chk
            // R6
            sec_hf_hold_chk: assert property (@(posedge clk) disable iff (rst)
                q_r.hf_act |=> q_r.hf_act);
            // R7
            sec_hf_pend_fixed_chk: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> $stable(q_r.hf_pend));
        end else begin : g_ns_chk
            // R6
            ns_hf_clear_rule_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(q_r.hf_act) |-> $past(hf_clr_ok && !wf.hf_act && !hf_set));
            // R6
            ns_hf_no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(q_r.hf_act) |-> $past(hf_set));
        end
    endgenerate

endmodule

// File: rtl/hstat_shared.sv
module hstat_shared
    import hstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  logic    sec,
    input  logic    grant,
    input  logic    cpu_sec,
    input  logic    nmi_set,
    input  shared_t wf,
    output shared_t q
);

    shared_t q_r;
    shared_t nxt;
    logic    wr_bus;
    logic    wr_sf;
    logic    nmi_clr;

    assign wr_bus  = wr & (sec | grant);
    assign wr_sf   = wr & sec;
    assign nmi_clr = wr & ~sec & cpu_sec & grant & ~wf.nmi_act;

    always_comb begin
        nxt = q_r;
        if (wr_bus) begin
            nxt.bus_act  = wf.bus_act;
            nxt.bus_pend = wf.bus_pend;
            nxt.bus_en   = wf.bus_en;
        end
        if (wr_sf) begin
            nxt.sf_act  = wf.sf_act;
            nxt.sf_en   = wf.sf_en;
            nxt.sf_pend = wf.sf_pend;
        end
        if (wr) begin
            nxt.dbg_act = wf.dbg_act;
        end
        nxt.nmi_act = nmi_set | (q_r.nmi_act & ~nmi_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            q_r <= nxt;
        end
    end

    assign q = q_r;

    // R4
    bus_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !sec && !grant) |=> $stable({q_r.bus_act, q_r.bus_pend, q_r.bus_en}));
    // R3
    sf_ns_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !sec) |=> $stable({q_r.sf_act, q_r.sf_en, q_r.sf_pend}));
    // R5
    nmi_clear_rule_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(q_r.nmi_act) |-> $past(wr && !sec && cpu_sec && grant && !wf.nmi_act));
    // R11
    nmi_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_set |=> q_r.nmi_act);

endmodule

// File: rtl/hstat_rdmux.sv
module hstat_rdmux
    import hstat_pkg::*;
(
    input  logic             rd_en,
    input  logic             sec,
    input  logic             grant,
    input  bank_t            s_bank,
    input  bank_t            n_bank,
    input  shared_t          sh,
    output logic [REG_W-1:0] word
);

    always_comb begin
        word = '0;
        if (rd_en) begin
            if (sec) begin
                word = bank_to_word(s_bank);
                word[B_SF_ACT]  = sh.sf_act;
                word[B_SF_EN]   = sh.sf_en;
                word[B_SF_PEND] = sh.sf_pend;
            end else begin
                word = bank_to_word(n_bank);
            end
            if (sec || grant) begin
                word[B_BUS_ACT]  = sh.bus_act;
                word[B_BUS_PEND] = sh.bus_pend;
                word[B_BUS_EN]   = sh.bus_en;
                word[B_NMI_ACT]  = sh.nmi_act;
            end
            word[B_DBG_ACT] = sh.dbg_act;
        end
    end

endmodule

// File: rtl/exc_hstat_reg.sv
module exc_hstat_reg
    import hstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_secure,
    input  logic [REG_W-1:0] req_wdata,
    input  logic             cpu_secure,
    input  logic             ns_grant,
    input  logic             evt_nmi_enter,
    input  logic             evt_hf_enter_s,
    input  logic             evt_hf_enter_ns,
    output logic [REG_W-1:0] rd_data,
    output logic             upd_strobe
);

    logic    wr;
    logic    rd;
    logic    ns_hf_clr_ok;
    bank_t   wf_bank;
    shared_t wf_sh;
    bank_t   s_q;
    bank_t   n_q;
    shared_t sh_q;
    logic    strobe_q;

    assign wr           = req_valid & req_write;
    assign rd           = req_valid & ~req_write;
    assign ns_hf_clr_ok = wr & ~req_secure & cpu_secure & ns_grant;
    assign wf_bank      = word_to_bank(req_wdata);
    assign wf_sh        = word_to_shared(req_wdata);

    hstat_bank #(.SECURE_BANK(1'b1)) u_sbank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr & req_secure),
        .hf_clr_ok(1'b0),
        .hf_set   (evt_hf_enter_s),
        .wf       (wf_bank),
        .q        (s_q)
    );

    hstat_bank #(.SECURE_BANK(1'b0)) u_nbank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr & ~req_secure),
        .hf_clr_ok(ns_hf_clr_ok),
        .hf_set   (evt_hf_enter_ns),
        .wf       (wf_bank),
        .q        (n_q)
    );

    hstat_shared u_shared (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .sec    (req_secure),
        .grant  (ns_grant),
        .cpu_sec(cpu_secure),
        .nmi_set(evt_nmi_enter),
        .wf     (wf_sh),
        .q      (sh_q)
    );

    hstat_rdmux u_rdmux (
        .rd_en (rd),
        .sec   (req_secure),
        .grant (ns_grant),
        .s_bank(s_q),
        .n_bank(n_q),
        .sh    (sh_q),
        .word  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wr;
        end
    end

    assign upd_strobe = strobe_q;

    // R9
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> upd_strobe);
    // R9
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> !upd_strobe);
    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & RSV_MASK) == '0);
    // R3
    ns_sf_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_secure) |->
            (rd_data[B_SF_ACT] == 1'b0 && rd_data[B_SF_EN] == 1'b0 && rd_data[B_SF_PEND] == 1'b0));
    // R4
    ns_bus_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_secure && !ns_grant) |->
            (rd_data[B_BUS_ACT] == 1'b0 && rd_data[B_NMI_ACT] == 1'b0));
    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |-> rd_data == '0);

endmodule

// File: tb/exc_hstat_reg_test.sv
module exc_hstat_reg_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] M_BANKW = 32'h0005_BC89; // freely writable banked bits
    localparam logic [31:0] M_BANKR = 32'h0025_BC8D; // banked bits visible on read
    localparam logic [31:0] M_SF    = 32'h0018_0010;
    localparam logic [31:0] M_BUS   = 32'h0002_4002;
    localparam logic [31:0] M_NMI   = 32'h0000_0020;
    localparam logic [31:0] M_DBG   = 32'h0000_0100;
    localparam logic [31:0] M_HFP   = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_secure;
    logic [31:0] req_wdata;
    logic        cpu_secure, ns_grant;
    logic        evt_nmi_enter, evt_hf_enter_s, evt_hf_enter_ns;
    logic [31:0] rd_data;
    logic        upd_strobe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_s, m_n, m_sh;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_hstat_reg uut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_secure     (req_secure),
        .req_wdata      (req_wdata),
        .cpu_secure     (cpu_secure),
        .ns_grant       (ns_grant),
        .evt_nmi_enter  (evt_nmi_enter),
        .evt_hf_enter_s (evt_hf_enter_s),
        .evt_hf_enter_ns(evt_hf_enter_ns),
        .rd_data        (rd_data),
        .upd_strobe     (upd_strobe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input bit sec, input bit g);
        logic [31:0] v;
        if (sec) v = (m_s & M_BANKR) | (m_sh & M_SF);
        else     v = m_n & M_BANKR;
        if (sec || g) v |= m_sh & (M_BUS | M_NMI);
        v |= m_sh & M_DBG;
        return v;
    endfunction

    task automatic model_write(input bit sec, input bit cs, input bit g, input logic [31:0] d);
        if (sec) begin
            m_s  = (m_s & ~M_BANKW) | (d & M_BANKW);
            m_sh = (m_sh & ~M_SF) | (d & M_SF);
        end else begin
            m_n = (m_n & ~(M_BANKW | M_HFP)) | (d & (M_BANKW | M_HFP));
            if (cs && g && !d[2]) m_n[2] = 1'b0;
            if (cs && g && !d[5]) m_sh[5] = 1'b0;
        end
        if (sec || g) m_sh = (m_sh & ~M_BUS) | (d & M_BUS);
        m_sh = (m_sh & ~M_DBG) | (d & M_DBG);
    endtask

    function automatic logic [31:0] pattern(input int k);
        case (k)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0000_0000;
            2: return 32'hAAAA_AAAA;
            3: return 32'h5555_5555;
            default: return (k * 32'h9E37_79B9) ^ 32'h0F0F_1234;
        endcase
    endfunction

    task automatic read_both(input bit g, input string tag);
        req_valid = 1'b1; req_write = 1'b0;
        req_secure = 1'b1; #1;
        check({tag, " secure view (R2 R3 R4 R5 R8 R10)"}, rd_data, model_read(1'b1, g));
        req_secure = 1'b0; #1;
        check({tag, " nonsecure view (R2 R3 R4 R5 R6 R7)"}, rd_data, model_read(1'b0, g));
        req_valid = 1'b0; #1;
        check({tag, " idle read zero R10"}, rd_data, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_secure = 0; req_wdata = '0;
        cpu_secure = 0; ns_grant = 0;
        evt_nmi_enter = 0; evt_hf_enter_s = 0; evt_hf_enter_ns = 0;
        m_s = '0; m_n = '0; m_sh = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, reserved bits
        ns_grant = 1'b1;
        read_both(1'b1, "reset R1");
        check("reset strobe R9", {31'h0, upd_strobe}, 32'h0);

        for (int sec = 0; sec < 2; sec++) begin
            for (int cs = 0; cs < 2; cs++) begin
                for (int g = 0; g < 2; g++) begin
                    for (int k = 0; k < 8; k++) begin
                        cpu_secure = cs[0];
                        ns_grant   = g[0];
                        if (k % 2 == 1) begin
                            // R11 entry events set the active flags
                            evt_nmi_enter = 1; evt_hf_enter_s = 1; evt_hf_enter_ns = 1;
                            @(negedge clk);
                            evt_nmi_enter = 0; evt_hf_enter_s = 0; evt_hf_enter_ns = 0;
                            m_sh[5] = 1'b1; m_s[2] = 1'b1; m_n[2] = 1'b1;
                            check("no strobe without write R9", {31'h0, upd_strobe}, 32'h0);
                            read_both(g[0], "after entry R11");
                        end
                        req_valid = 1; req_write = 1; req_secure = sec[0];
                        req_wdata = pattern(k + 8 * (g + 2 * cs));
                        model_write(sec[0], cs[0], g[0], req_wdata);
                        @(negedge clk);
                        req_valid = 0; req_write = 0;
                        check("strobe after write R9", {31'h0, upd_strobe}, 32'h1);
                        read_both(g[0], "sweep");
                        // reads with the opposite grant (R4 R5 gating on reads)
                        ns_grant = ~g[0];
                        read_both(~g[0], "grant flipped R4");
                        ns_grant = g[0];
                        @(negedge clk);
                        check("strobe single cycle R9", {31'h0, upd_strobe}, 32'h0);
                    end
                end
            end
        end

        // R11 set wins over a permitted clear in the same cycle
        cpu_secure = 1; ns_grant = 1;
        req_valid = 1; req_write = 1; req_secure = 0; req_wdata = 32'h0;
        evt_nmi_enter = 1; evt_hf_enter_ns = 1;
        model_write(1'b0, 1'b1, 1'b1, 32'h0);
        m_sh[5] = 1'b1; m_n[2] = 1'b1;
        @(negedge clk);
        req_valid = 0; req_write = 0; evt_nmi_enter = 0; evt_hf_enter_ns = 0;
        read_both(1'b1, "set beats clear R11");

        // R5 R6 the same permitted clear without a competing set
        req_valid = 1; req_write = 1; req_secure = 0; req_wdata = 32'h0;
        model_write(1'b0, 1'b1, 1'b1, 32'h0);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        read_both(1'b1, "permitted clear R5 R6");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule